// File: doc/BRIEF.md
# Page-Buffered Flash Write Sequencer

This block is a synchronous, clocked model of the write path of a word-wide non-volatile memory. A host loads 16-bit words into a page buffer with write strobes. A strobe is chip select low, write strobe low and output enable high. The page buffer is 128 words deep. The load phase has no closing command. It ends when the host stops writing for a programmable number of clocks. The block then starts a timed internal programming run. That run copies the whole page into the backing word array. Any word the host did not load in this page is stored as all-ones.

While the programming run is in progress, the busy flag is high. A host read during that time returns a status word instead of array data. Bit 7 of the status word is the inverse of bit 7 of the last accepted word. Bit 6 flips on every new read access. Software can poll either bit to detect the end of the run. Once the run ends, reads return array contents again.

A word whose page differs from the first word of the load phase is dropped, and a sticky mismatch flag is set. Writes issued while the array is busy are dropped. The array holds 2^ADDR_W words, and ADDR_W = 16 gives 64K words. The load window and the run length are clock-count parameters. The run length must be at least the page size.

Top module: `pgwr_seq`

## Requirements
- R1: A word is loaded only by a strobe with `chip_sel_n`=0, `wr_stb_n`=0 and `out_en_n`=1. A strobe with `out_en_n` low loads nothing.
- R2: The address is taken in the first clock of a write strobe. The data is taken in the last clock in which the strobe is active.
- R3: Address bits [ADDR_W-1:7] select the page and bits [6:0] select the word within the page. Page p, word w lives at array address p*128+w.
- R4: Words of a page can be loaded in any order, and each one lands at its own word position.
- R5: Each write strobe that starts less than LOAD_WIN clocks after the previous one ended keeps the load phase open. If no strobe arrives, `prog_busy` rises on the (LOAD_WIN+1)th rising clock edge after the strobe is released. The first edge that sees the strobe released counts as edge 1.
- R6: `prog_busy` stays high for exactly PROG_CYC clocks. After it falls, the array holds the page.
- R7: Each word loaded in the phase is stored as the data of its last load. Every word of the page not loaded in the phase is stored as 16'hFFFF.
- R8: A word whose page differs from the page of the first word of the phase is not stored. It sets `page_mismatch`, which stays high until reset.
- R9: Write strobes while `prog_busy` is high are ignored. They store nothing and start no further programming run.
- R10: While `prog_busy` is high, each read returns the same status word. Bit 7 is the inverse of bit 7 of the last accepted word. Bit 6 takes the opposite value from the one returned by the previous read access. All other bits are 0.
- R11: In the clock after each edge that samples `chip_sel_n`=0 and `out_en_n`=0, `rd_valid` is 1 and `rd_data` carries the result. Otherwise `rd_valid` and `rd_data` are 0. After reset, `prog_busy`, `page_mismatch` and `rd_valid` are 0.
- R12: While `prog_busy` is low, including during a load phase, a read returns the word currently in the array. Pages not being programmed keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_sel_n | input | 1 | Active-low device select |
| wr_stb_n | input | 1 | Active-low write strobe |
| out_en_n | input | 1 | Active-low output enable |
| word_addr | input | ADDR_W | Word address: page in the upper bits, word in the low 7 bits |
| wr_data | input | DATA_W | Word to load |
| rd_data | output | DATA_W | Registered read result or polling status |
| rd_valid | output | 1 | High in the clock that follows a sampled read access |
| prog_busy | output | 1 | High while the internal programming run is active |
| page_mismatch | output | 1 | Sticky flag for a word loaded to the wrong page |

## Verification
The checker's load-timeout property assumes that a write strobe is a clean run of active clocks. It also assumes that the strobes of one load phase are separated by quiet clocks. The stimulus holds each strobe for two clocks and releases it for at least one clock before the next strobe. The polling-mask and run-length properties assume that read and write strobes are never active in the same clock. The bench keeps them apart by always raising output enable during writes and write strobe during reads. Writes during a busy run are issued only well inside the run, so no strobe straddles its end.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

    // Sequencer phases
    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_LOAD = 2'd1,
        PS_PROG = 2'd2
    } pg_state_e;

    // Bit positions of the polling status word
    localparam int POLL_DATA_BIT   = 7;
    localparam int POLL_TOGGLE_BIT = 6;

endpackage

// File: rtl/pgwr_strobe.sv
// Write strobe qualifier: address on first active clock, data on last active clock.
module pgwr_strobe #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_sel_n,
    input  logic              wr_stb_n,
    input  logic              out_en_n,
    input  logic [ADDR_W-1:0] word_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_act,
    output logic              ld_vld,
    output logic [ADDR_W-1:0] ld_addr,
    output logic [DATA_W-1:0] ld_data
);

    typedef struct packed {
        logic              act;
        logic [ADDR_W-1:0] a;
        logic [DATA_W-1:0] d;
    } stb_t;

    stb_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        wr_act  = !chip_sel_n && !wr_stb_n && out_en_n;
        s_d.act = wr_act;
        if (wr_act && !s_q.act) begin
            s_d.a = word_addr;
        end
        if (wr_act) begin
            s_d.d = wr_data;
        end
        ld_vld  = s_q.act && !wr_act;
        ld_addr = s_q.a;
        ld_data = s_q.d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/pgwr_pagebuf.sv
// Page buffer with a per-word loaded bitmap; unloaded words read as all-ones.
module pgwr_pagebuf #(
    parameter int DATA_W = 16,
    parameter int PAGE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic [PAGE_W-1:0] widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PAGE_W-1:0] ridx,
    output logic [DATA_W-1:0] rdata
);

    localparam int WORDS = 1 << PAGE_W;

    logic [WORDS-1:0]  vld_d, vld_q;
    logic [DATA_W-1:0] mem [WORDS];

    always_comb begin
        vld_d = clr ? '0 : vld_q;
        if (we) begin
            vld_d[widx] = 1'b1;
        end
        rdata = vld_q[ridx] ? mem[ridx] : '1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            vld_q <= vld_d;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem[widx] <= wdata;
        end
    end

endmodule

// File: rtl/pgwr_array.sv
// Backing word array: one synchronous write port, one combinational read port.
module pgwr_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata = mem[raddr];
    end

endmodule

// File: rtl/pgwr_seq.sv
// Page-buffered write sequencer: load window, timed programming run, polled reads.
module pgwr_seq
    import pgwr_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 16,
    parameter int PAGE_W   = 7,
    parameter int LOAD_WIN = 40000,
    parameter int PROG_CYC = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_sel_n,
    input  logic              wr_stb_n,
    input  logic              out_en_n,
    input  logic [ADDR_W-1:0] word_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              prog_busy,
    output logic              page_mismatch
);

    localparam int PAGE_WORDS = 1 << PAGE_W;
    localparam int PG_NUM_W   = ADDR_W - PAGE_W;
    localparam int LW_W       = $clog2(LOAD_WIN + 1);
    localparam int PC_W       = $clog2(PROG_CYC + 1);

    typedef struct packed {
        pg_state_e           st;
        logic [PG_NUM_W-1:0] page;
        logic [LW_W-1:0]     tmr;
        logic [PC_W-1:0]     pcnt;
        logic                last7;
        logic                err;
        logic                tgl;
        logic                rd_act;
        logic                rd_en;
        logic [DATA_W-1:0]   rdat;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        st: PS_IDLE, page: '0, tmr: '0, pcnt: '0, last7: 1'b0,
        err: 1'b0, tgl: 1'b0, rd_act: 1'b0, rd_en: 1'b0, rdat: '0
    };

    ctl_t c_d, c_q;

    logic              wr_act, ld_vld;
    logic [ADDR_W-1:0] ld_addr;
    logic [DATA_W-1:0] ld_data;
    logic              buf_we, buf_clr, arr_we;
    logic [DATA_W-1:0] buf_rdata, arr_rdata;
    logic [ADDR_W-1:0] arr_waddr;
    logic              same_page, rd_now;

    pgwr_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_strobe (
        .clk        (clk),
        .rst_n      (rst_n),
        .chip_sel_n (chip_sel_n),
        .wr_stb_n   (wr_stb_n),
        .out_en_n   (out_en_n),
        .word_addr  (word_addr),
        .wr_data    (wr_data),
        .wr_act     (wr_act),
        .ld_vld     (ld_vld),
        .ld_addr    (ld_addr),
        .ld_data    (ld_data)
    );

    pgwr_pagebuf #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_pagebuf (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (buf_clr),
        .we    (buf_we),
        .widx  (ld_addr[PAGE_W-1:0]),
        .wdata (ld_data),
        .ridx  (c_q.pcnt[PAGE_W-1:0]),
        .rdata (buf_rdata)
    );

    pgwr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk   (clk),
        .we    (arr_we),
        .waddr (arr_waddr),
        .wdata (buf_rdata),
        .raddr (word_addr),
        .rdata (arr_rdata)
    );

    always_comb begin
        c_d       = c_q;
        buf_we    = 1'b0;
        buf_clr   = 1'b0;
        arr_we    = 1'b0;
        arr_waddr = {c_q.page, c_q.pcnt[PAGE_W-1:0]};
        same_page = (ld_addr[ADDR_W-1:PAGE_W] == c_q.page);

        case (c_q.st)
            PS_IDLE: begin
                if (ld_vld) begin
                    c_d.page  = ld_addr[ADDR_W-1:PAGE_W];
                    c_d.last7 = ld_data[POLL_DATA_BIT];
                    c_d.tmr   = '0;
                    c_d.st    = PS_LOAD;
                    buf_we    = 1'b1;
                end
            end
            PS_LOAD: begin
                if (ld_vld) begin
                    if (same_page) begin
                        buf_we    = 1'b1;
                        c_d.last7 = ld_data[POLL_DATA_BIT];
                    end else begin
                        c_d.err = 1'b1;
                    end
                end
                if (ld_vld || wr_act) begin
                    c_d.tmr = '0;
                end else if (c_q.tmr == LW_W'(LOAD_WIN - 1)) begin
                    c_d.st   = PS_PROG;
                    c_d.pcnt = '0;
                end else begin
                    c_d.tmr = c_q.tmr + 1'b1;
                end
            end
            PS_PROG: begin
                arr_we = (c_q.pcnt < PC_W'(PAGE_WORDS));
                if (c_q.pcnt == PC_W'(PROG_CYC - 1)) begin
                    c_d.st  = PS_IDLE;
                    buf_clr = 1'b1;
                end else begin
                    c_d.pcnt = c_q.pcnt + 1'b1;
                end
            end
            default: begin
                c_d.st = PS_IDLE;
            end
        endcase

        rd_now     = !chip_sel_n && !out_en_n;
        c_d.rd_act = rd_now;
        c_d.rd_en  = rd_now;
        if (rd_now) begin
            if (c_q.st == PS_PROG) begin
                c_d.rdat                  = '0;
                c_d.rdat[POLL_DATA_BIT]   = ~c_q.last7;
                c_d.rdat[POLL_TOGGLE_BIT] = c_q.rd_act ? c_q.tgl : ~c_q.tgl;
                if (!c_q.rd_act) begin
                    c_d.tgl = ~c_q.tgl;
                end
            end else begin
                c_d.rdat = arr_rdata;
            end
        end else begin
            c_d.rdat = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= CTL_RST;
        end else begin
            c_q <= c_d;
        end
    end

    assign rd_data       = c_q.rdat;
    assign rd_valid      = c_q.rd_en;
    assign prog_busy     = (c_q.st == PS_PROG);
    assign page_mismatch = c_q.err;

endmodule

// File: rtl/pgwr_seq_chk.sv
// Port-level checker for pgwr_seq, bound to every instance.
module pgwr_seq_chk #(
    parameter int DATA_W   = 16,
    parameter int LOAD_WIN = 40000,
    parameter int PROG_CYC = 1000000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chip_sel_n,
    input logic              wr_stb_n,
    input logic              out_en_n,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid,
    input logic              prog_busy,
    input logic              page_mismatch
);

    logic        stb_on;
    logic [31:0] quiet_q;
    logic [31:0] busy_len_q;

    assign stb_on = !chip_sel_n && !wr_stb_n && out_en_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quiet_q    <= '0;
            busy_len_q <= '0;
        end else begin
            if (stb_on) begin
                quiet_q <= '0;
            end else if (quiet_q != 32'hFFFF_FFFF) begin
                quiet_q <= quiet_q + 1;
            end
            busy_len_q <= prog_busy ? busy_len_q + 1 : '0;
        end
    end

    AST_LOAD_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_busy) |-> (quiet_q == 32'(LOAD_WIN + 1))); // R5

    AST_PROG_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prog_busy) |-> (busy_len_q == 32'(PROG_CYC))); // R6

    AST_READ_VALID_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (!chip_sel_n && !out_en_n) |=> rd_valid); // R11

    AST_READ_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !(!chip_sel_n && !out_en_n) |=> (!rd_valid && rd_data == '0)); // R11

    AST_MISMATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        page_mismatch |=> page_mismatch); // R8

    AST_POLL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(prog_busy)) |-> ((rd_data & ~DATA_W'(8'hC0)) == '0)); // R10

endmodule

bind pgwr_seq pgwr_seq_chk #(
    .DATA_W   (DATA_W),
    .LOAD_WIN (LOAD_WIN),
    .PROG_CYC (PROG_CYC)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .chip_sel_n    (chip_sel_n),
    .wr_stb_n      (wr_stb_n),
    .out_en_n      (out_en_n),
    .rd_data       (rd_data),
    .rd_valid      (rd_valid),
    .prog_busy     (prog_busy),
    .page_mismatch (page_mismatch)
);

// File: tb/pgwr_seq_test.sv
`timescale 1ns/1ps
module pgwr_seq_test;

    localparam int AW   = 9;
    localparam int DW   = 16;
    localparam int PW   = 7;
    localparam int LW   = 20;
    localparam int PC   = 160;
    localparam int NW   = 1 << AW;
    localparam int PWDS = 1 << PW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chip_sel_n = 1'b1, wr_stb_n = 1'b1, out_en_n = 1'b1;
    logic [AW-1:0] word_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          rd_valid, prog_busy, page_mismatch;

    always #2.5 clk = ~clk;

    pgwr_seq #(.ADDR_W(AW), .DATA_W(DW), .PAGE_W(PW), .LOAD_WIN(LW), .PROG_CYC(PC)) uut (
        .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .wr_stb_n(wr_stb_n),
        .out_en_n(out_en_n), .word_addr(word_addr), .wr_data(wr_data),
        .rd_data(rd_data), .rd_valid(rd_valid), .prog_busy(prog_busy),
        .page_mismatch(page_mismatch)
    );

    int total = 0, bad = 0;
    int episodes = 0, last_len = 0, run = 0;
    bit finished = 0;
    logic [DW-1:0] model [NW];
    bit            known [NW];
    logic [DW-1:0] pbuf [PWDS];
    bit            pld  [PWDS];
    logic [DW-1:0] lastd;

    // programming-run length logger, sampled away from the active edge
    always @(negedge clk) begin
        if (prog_busy) run++;
        else if (run != 0) begin last_len = run; run = 0; episodes++; end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] fdat(input int p, input int w, input int s);
        return DW'((p * 4099 + w * 613 + s * 97) ^ 16'hA5C3);
    endfunction

    task automatic wr(input logic [AW-1:0] a0, input logic [DW-1:0] d0,
                      input logic [AW-1:0] a1, input logic [DW-1:0] d1, input bit oe_low);
        @(negedge clk);
        chip_sel_n = 1'b0; wr_stb_n = 1'b0; out_en_n = oe_low ? 1'b0 : 1'b1;
        word_addr = a0; wr_data = d0;
        @(negedge clk);
        word_addr = a1; wr_data = d1;
        @(negedge clk);
        chip_sel_n = 1'b1; wr_stb_n = 1'b1; out_en_n = 1'b1;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic en);
        @(negedge clk);
        chip_sel_n = 1'b0; out_en_n = 1'b0; wr_stb_n = 1'b1; word_addr = a;
        @(negedge clk);
        d = rd_data; en = rd_valid;
        chip_sel_n = 1'b1; out_en_n = 1'b1;
    endtask

    task automatic ld(input int p, input int w, input logic [DW-1:0] d);
        wr(AW'(p * PWDS + w), d, AW'(p * PWDS + w), d, 1'b0);
        pbuf[w] = d; pld[w] = 1'b1; lastd = d;
    endtask

    task automatic start_page();
        for (int w = 0; w < PWDS; w++) pld[w] = 1'b0;
    endtask

    task automatic commit(input int p);
        for (int w = 0; w < PWDS; w++) begin
            model[p * PWDS + w] = pld[w] ? pbuf[w] : 16'hFFFF;
            known[p * PWDS + w] = 1'b1;
        end
    endtask

    task automatic wait_done();
        while (!prog_busy) @(negedge clk);
        while (prog_busy) @(negedge clk);
        @(negedge clk);
        chk(last_len == PC, "R6 busy length", 32'(last_len), 32'(PC));
    endtask

    task automatic check_page(input int p, input string req);
        logic [DW-1:0] d; logic en;
        for (int w = 0; w < PWDS; w++) begin
            rd(AW'(p * PWDS + w), d, en);
            chk(en == 1'b1 && d == model[p * PWDS + w], req, {15'd0, en, d}, {16'd1, model[p * PWDS + w]});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d; logic en; logic prev6;
        bit sel [PWDS];
        int u, u2, w1, e;

        repeat (3) @(negedge clk);
        // R11: reset state
        chk(prog_busy == 1'b0, "R11 reset busy", 32'(prog_busy), 32'd0);
        chk(page_mismatch == 1'b0, "R11 reset mismatch", 32'(page_mismatch), 32'd0);
        chk(rd_valid == 1'b0, "R11 reset valid", 32'(rd_valid), 32'd0);
        rst_n = 1'b1;

        // Page 0: full page in descending order (R3, R4, R7), exact timeout (R5)
        start_page();
        for (int w = PWDS - 1; w >= 0; w--) ld(0, w, fdat(0, w, 0));
        for (int k = 1; k <= LW + 1; k++) begin
            @(negedge clk);
            if (k == LW) chk(prog_busy == 1'b0, "R5 busy still low", 32'(prog_busy), 32'd0);
            if (k == LW + 1) chk(prog_busy == 1'b1, "R5 busy risen", 32'(prog_busy), 32'd1);
        end
        // R10: polling while busy
        for (int i = 0; i < 4; i++) begin
            rd(AW'(i), d, en);
            chk(en == 1'b1 && d[7] == ~lastd[7] && (d & 16'hFF3F) == 16'h0000,
                "R10 poll word", {15'd0, en, d}, {16'd1, 8'h00, ~lastd[7], 7'h00});
            if (i > 0) chk(d[6] != prev6, "R10 toggle bit", 32'(d[6]), 32'(~prev6));
            prev6 = d[6];
        end
        wait_done();
        commit(0);
        check_page(0, "R4 R7 page0 contents");

        // Page 1: partial load in scrambled order with R1, R2, R8, R12 probes
        start_page();
        for (int w = 0; w < PWDS; w++) sel[w] = 1'b0;
        for (int k = 0; k < 48; k++) sel[(k * 41) % PWDS] = 1'b1;
        u = -1; u2 = -1;
        for (int w = 0; w < PWDS; w++) begin
            if (!sel[w] && u < 0) u = w;
            else if (!sel[w] && u2 < 0) u2 = w;
        end
        ld(1, 0, fdat(1, 0, 1));
        // R1: strobe with output enable low is not a write
        wr(AW'(PWDS + u), 16'h0BAD, AW'(PWDS + u), 16'h0BAD, 1'b1);
        // R8: off-page word
        chk(page_mismatch == 1'b0, "R8 mismatch before", 32'(page_mismatch), 32'd0);
        wr(AW'(2 * PWDS + 5), 16'h7777, AW'(2 * PWDS + 5), 16'h7777, 1'b0);
        @(negedge clk);
        chk(page_mismatch == 1'b1, "R8 mismatch set", 32'(page_mismatch), 32'd1);
        // R12: array read during load phase
        rd(AW'(9), d, en);
        chk(en == 1'b1 && d == model[9], "R12 read during load", 32'(d), 32'(model[9]));
        // R2: address from first clock, data from last clock
        w1 = 41;
        wr(AW'(PWDS + w1), 16'hDEAD, AW'(PWDS + u2), fdat(1, w1, 1), 1'b0);
        pbuf[w1] = fdat(1, w1, 1); pld[w1] = 1'b1; lastd = pbuf[w1];
        for (int k = 2; k < 48; k++) ld(1, (k * 41) % PWDS, fdat(1, (k * 41) % PWDS, 1));
        while (!prog_busy) @(negedge clk);
        // R9: writes during busy
        e = episodes;
        wr(AW'(PWDS + u), 16'h1234, AW'(PWDS + u), 16'h1234, 1'b0);
        wr(AW'(3 * PWDS + 3), 16'h4321, AW'(3 * PWDS + 3), 16'h4321, 1'b0);
        wait_done();
        repeat (3 * LW) @(negedge clk);
        chk(episodes == e + 1, "R9 no extra run", 32'(episodes), 32'(e + 1));
        chk(prog_busy == 1'b0, "R9 stays idle", 32'(prog_busy), 32'd0);
        commit(1);
        chk(model[PWDS + u] == 16'hFFFF, "R1 model sanity", 32'(model[PWDS + u]), 32'hFFFF);
        rd(AW'(PWDS + u), d, en);
        chk(d == 16'hFFFF, "R1 R9 ignored word", 32'(d), 32'hFFFF);
        rd(AW'(PWDS + u2), d, en);
        chk(d == 16'hFFFF, "R2 second address unused", 32'(d), 32'hFFFF);
        rd(AW'(PWDS + w1), d, en);
        chk(d == fdat(1, w1, 1), "R2 first address last data", 32'(d), 32'(fdat(1, w1, 1)));
        check_page(1, "R7 page1 contents");
        chk(page_mismatch == 1'b1, "R8 mismatch sticky", 32'(page_mismatch), 32'd1);

        // Pages 2 and 3: ascending, with a word reloaded on page 3 (R7)
        start_page();
        for (int w = 0; w < PWDS; w++) ld(2, w, fdat(2, w, 2));
        wait_done();
        commit(2);
        start_page();
        ld(3, 0, 16'h00FF);
        for (int w = 1; w < PWDS; w++) ld(3, w, fdat(3, w, 3));
        ld(3, 0, 16'hC3C3);
        wait_done();
        commit(3);

        // Full sweep of the array (R3, R12)
        for (int a = 0; a < NW; a++) begin
            if (known[a]) begin
                rd(AW'(a), d, en);
                chk(en == 1'b1 && d == model[a], "R3 R12 sweep", {15'd0, en, d}, {16'd1, model[a]});
            end
        end

        // Reset clears the mismatch flag (R8)
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(page_mismatch == 1'b0, "R8 cleared by reset", 32'(page_mismatch), 32'd0);
        rst_n = 1'b1;

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule